// File: doc/BRIEF.md
# Gated Word Serializer

The block turns a parallel word into a serial stream, one bit per rising edge of a fast bit clock, least significant bit first. Alongside the stream it drives a frame clock whose period equals one word: it goes high in the slot that carries bit 0 and drops halfway through the word. An upstream pattern source can treat the rising frame edge as its trigger and present the next word. That word is then captured at the following word boundary.

A synchronous freeze input stops all activity without cutting a bit short. The falling bit-clock edge samples freeze. When the sampled value is high, the next rising edge neither shifts, counts nor advances the frame, and every output keeps its value. When the sampled value returns low, the stream continues with the bit that would have come next.

A small controller with three named states sequences the block. ST_START is entered on reset and waits for the first unfrozen slot, where it loads a word and moves to ST_SHIFT. ST_SHIFT advances one bit per active slot and reloads after the last bit. Any sampled freeze outside ST_START moves the controller to ST_FROZEN. The first unfrozen slot moves it from ST_FROZEN back to ST_SHIFT. A freeze seen in ST_START keeps the controller in ST_START.

Top module: `gated_serializer`

## Requirements
- R1: A synchronous active-high reset sets the bit counter to 0, drives `ser_out` low and `frame_out` low, and returns the controller to ST_START.
- R2: After reset, the first unfrozen rising edge captures `par_in` and puts its bit 0 on `ser_out`.
- R3: The bits of each word leave in ascending index order, bit 0 first and bit WORD_W-1 last, one per active slot.
- R4: In the active slot after bit WORD_W-1, a new word is captured from `par_in` and its bit 0 is sent. No slot is skipped or repeated between words.
- R5: `frame_out` is high on the slots carrying bits 0 to WORD_W/2-1 and low on the rest. It therefore rises exactly on the bit-0 slot of each word.
- R6: `freeze` is sampled only on the falling bit-clock edge. A high sample stops the next rising edge. A pulse that falls between two falling edges without being sampled has no effect.
- R7: While a frozen edge occurs, `ser_out`, `frame_out` and the bit counter hold their values. Across any freeze window, no bit is dropped or duplicated.
- R8: After `freeze` is sampled low on a falling edge, the next rising edge resumes with the bit that follows the one held.
- R9: `par_in` has no effect except on the load slot. Changing it mid-word does not change the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock. Outputs update on the rising edge; freeze is sampled on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| freeze | input | 1 | High suspends all activity; low resumes it |
| par_in | input | WORD_W | Parallel word, captured on the load slot |
| ser_out | output | 1 | Serial data, LSB first |
| frame_out | output | 1 | Word-rate frame clock, high for the first half of each word |

## Verification
If the bit counter is off by one, the bits of every word come out rotated on `ser_out`, and `frame_out` rises on the wrong slot in the very next word. A frozen edge that still advances the counter, or a resume that repeats one, shows up as a lost or doubled bit within one word. The bench rebuilds each word from the active slots and compares it with the word that was presented.

// File: rtl/gated_serializer_pkg.sv
package gated_serializer_pkg;
    typedef enum logic [1:0] {
        ST_START  = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FROZEN = 2'd2
    } ser_state_t;
endpackage

// File: rtl/gser_freeze_sampler.sv
module gser_freeze_sampler (
    input  logic clk,
    input  logic rst,
    input  logic freeze,
    output logic frz_q
);
    // Falling-edge sample: decision settles half a bit before the next rising edge
    always_ff @(negedge clk) begin
        if (rst) frz_q <= 1'b0;
        else     frz_q <= freeze;
    end

    p_negedge_sample_r6: assert property (@(negedge clk) disable iff (rst)
        freeze |=> frz_q);
    p_negedge_release_r8: assert property (@(negedge clk) disable iff (rst)
        !freeze |=> !frz_q);
endmodule

// File: rtl/gser_ctrl.sv
module gser_ctrl
    import gated_serializer_pkg::*;
#(
    parameter int WORD_W = 8,
    localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frz_q,
    output logic          load,
    output logic          adv,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nxt
);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    ser_state_t state, state_nxt;

    // State register and bit counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_START;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            if (load)     cnt <= '0;
            else if (adv) cnt <= cnt_nxt;
        end
    end

    // Next state and strobes
    always_comb begin
        cnt_nxt = cnt + CW'(1);
        load    = 1'b0;
        adv     = 1'b0;
        unique case (state)
            ST_START: begin
                load      = !frz_q;
                state_nxt = frz_q ? ST_START : ST_SHIFT;
            end
            ST_SHIFT, ST_FROZEN: begin
                load      = !frz_q && (cnt == LAST);
                adv       = !frz_q && (cnt != LAST);
                state_nxt = frz_q ? ST_FROZEN : ST_SHIFT;
            end
            default: begin
                state_nxt = ST_START;
            end
        endcase
    end

    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (!frz_q && state != ST_START && cnt == LAST) |=> (cnt == '0));
    p_cnt_hold_r7: assert property (@(posedge clk) disable iff (rst)
        frz_q |=> $stable(cnt));
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(load && adv));
endmodule

// File: rtl/gser_datapath.sv
module gser_datapath #(
    parameter int WORD_W = 8,
    localparam int CW   = (WORD_W > 1) ? $clog2(WORD_W) : 1,
    localparam int HALF = (WORD_W > 1) ? WORD_W / 2 : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic [CW-1:0]     cnt_nxt,
    input  logic [WORD_W-1:0] par_in,
    output logic              ser_out,
    output logic              frame_out
);
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q    <= '0;
            ser_out   <= 1'b0;
            frame_out <= 1'b0;
        end else if (load) begin
            word_q    <= par_in;
            ser_out   <= par_in[0];
            frame_out <= 1'b1;
        end else if (adv) begin
            ser_out   <= word_q[cnt_nxt];
            frame_out <= (cnt_nxt < CW'(HALF));
        end
    end

    p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> ($stable(ser_out) && $stable(frame_out) && $stable(word_q)));
    p_word_keep_r9: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(word_q));
endmodule

// File: rtl/gated_serializer.sv
module gated_serializer #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              freeze,
    input  logic [WORD_W-1:0] par_in,
    output logic              ser_out,
    output logic              frame_out
);
    localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic          frz_q;
    logic          load;
    logic          adv;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;

    gser_freeze_sampler u_smp (
        .clk    (clk),
        .rst    (rst),
        .freeze (freeze),
        .frz_q  (frz_q)
    );

    gser_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .frz_q   (frz_q),
        .load    (load),
        .adv     (adv),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt)
    );

    gser_datapath #(.WORD_W(WORD_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .adv       (adv),
        .cnt_nxt   (cnt_nxt),
        .par_in    (par_in),
        .ser_out   (ser_out),
        .frame_out (frame_out)
    );

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!ser_out && !frame_out && cnt == '0));
    p_frame_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_out) |-> (cnt == '0));
endmodule

// File: tb/gated_serializer_tb.sv
`timescale 1ns/1ps
module gated_serializer_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         freeze = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         ser_out;
    logic         frame_out;

    int n_chk = 0;
    int n_bad = 0;

    // bench model state
    bit           m_started;
    int           m_cnt;
    logic [W-1:0] m_word;
    logic         m_sout;
    logic         m_frame;
    bit           m_active;
    logic [W-1:0] exp_q[$];
    logic [W-1:0] asm_w;
    int           asm_n;

    always #2.5 clk = ~clk;

    gated_serializer #(.WORD_W(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .freeze    (freeze),
        .par_in    (par_in),
        .ser_out   (ser_out),
        .frame_out (frame_out)
    );

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        summary();
        $finish;
    end

    task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic frame_for(int idx);
        return idx < W / 2;
    endfunction

    // model of one rising edge, from the requirements
    task automatic model(bit r, bit f, logic [W-1:0] d);
        m_active = 0;
        if (r) begin
            m_started = 0; m_cnt = 0; m_sout = 0; m_frame = 0;
            exp_q.delete(); asm_n = 0;
        end else if (!f) begin
            m_active = 1;
            if (!m_started || m_cnt == W - 1) begin
                m_started = 1; m_word = d; m_cnt = 0;
                exp_q.push_back(d);
            end else begin
                m_cnt++;
            end
            m_sout  = m_word[m_cnt];
            m_frame = frame_for(m_cnt);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "ser_out", W'(ser_out), W'(m_sout));
        chk("R5", "frame_out", W'(frame_out), W'(m_frame));
        if (m_active) begin
            asm_w[asm_n] = ser_out;
            asm_n++;
            if (asm_n == W) begin
                // R3 R4 R7: rebuilt word equals presented word, no drop or repeat
                chk("R3 R4 R7", "rebuilt word", asm_w, exp_q.pop_front());
                asm_n = 0;
            end
        end
    endtask

    // called at posedge+1: drive, advance one edge, sample at posedge+1
    task automatic step(string tag, bit r, bit f, logic [W-1:0] d);
        rst = r; freeze = f; par_in = d;
        model(r, f, d);
        @(posedge clk); #1;
        compare(tag);
    endtask

    // freeze pulse between two falling edges: never sampled
    task automatic glitch_step(logic [W-1:0] d);
        rst = 0; freeze = 0; par_in = d;
        model(0, 0, d);
        #2 freeze = 1;
        @(posedge clk); #1;
        freeze = 0;
        compare("R6");
    endtask

    initial begin
        logic [W-1:0] cur;
        void'($urandom(32'h5EED_0446));
        @(posedge clk); #1;
        model(1, 0, '0);
        for (int i = 0; i < 3; i++) step("R1", 1, 0, 8'hFF);

        // first load right after reset, then a full word and a frozen start
        step("R2", 0, 1, 8'h3C);
        step("R2", 0, 1, 8'h3C);
        cur = 8'hA5;
        step("R2", 0, 0, cur);
        for (int i = 0; i < 7; i++) step("R3", 0, 0, cur);
        cur = 8'h81;
        for (int i = 0; i < 8; i++) step("R4", 0, 0, cur);

        // R9: par_in scrambled mid-word does not alter the word on the line
        cur = 8'h6E;
        step("R9", 0, 0, cur);
        for (int i = 0; i < 7; i++) step("R9", 0, 0, ~cur ^ W'(i));
        for (int i = 0; i < 8; i++) step("R9", 0, 0, 8'h17);

        // R6: glitch never sampled; single-slot freeze at each bit position
        for (int i = 0; i < 8; i++) glitch_step(8'h17);
        for (int pos = 0; pos < 8; pos++) begin
            for (int i = 0; i < pos; i++) step("R7", 0, 0, 8'hD2);
            step("R6", 0, 1, 8'hD2);
            step("R7", 0, 1, 8'hD2);
            step("R8", 0, 0, 8'hD2);
            for (int i = pos + 1; i < 8; i++) step("R8", 0, 0, 8'hD2);
        end

        // mid-word reset, then frozen start
        for (int i = 0; i < 3; i++) step("R4", 0, 0, 8'h99);
        step("R1", 1, 0, 8'h99);
        step("R1", 0, 1, 8'h42);
        for (int i = 0; i < 16; i++) step("R2", 0, 0, 8'h42);

        // random words paced by frame rise, random freeze windows
        cur = W'($urandom);
        for (int i = 0; i < 2500; i++) begin
            bit prev_fr;
            int run;
            prev_fr = frame_out;
            if (($urandom % 10) == 0) begin
                run = 1 + ($urandom % 12);
                for (int k = 0; k < run; k++) step("R7", 0, 1, cur);
            end
            if (($urandom % 23) == 0) glitch_step(cur);
            else step("R8", 0, 0, cur);
            if (frame_out && !prev_fr) cur = W'($urandom);
        end

        summary();
        $finish;
    end
endmodule